// File: doc/BRIEF.md
# JTAG User-Register Command Bridge

This block sits behind a user data register of a JTAG TAP and gives a host a small, parity-protected command channel into a hashing engine. The host shifts fixed-format frames through the data register. Each frame is either a write, which carries a 32-bit value and a 4-bit address, or a short read request. The block checks the length and the odd parity of every frame. It then updates its register file or arms a read. The armed value is shifted out on TDO during the next data-register scan.

The register file holds eight midstate words, three block-tail words and a clock-setting word, and all of these drive output ports. A write to the last block-tail word starts a new job. The hashing core pushes found nonces into a 16-entry FIFO. The host pops this FIFO by reading the result address and keeps reading until it gets all-ones. For this reason the FIFO keeps stale results in arrival order. When the FIFO is full, a new nonce is dropped and a sticky flag records the loss.

The TAP controller, the hashing core and the clock synthesizer lie outside the block. The block sees only the Capture-DR, Shift-DR and Update-DR strobes and TDI, all synchronous to `clk`.

Top module: `jtag_reg_bridge`

## Requirements
- R1: A write frame is 38 bits shifted LSB first. Bits 0-31 carry the data, bits 32-35 the address, bit 36 the write flag (1) and bit 37 the parity bit. On Update-DR a valid write stores the data. Addresses 1-8 drive `midstate` (address k at bits 32(k-1)+31:32(k-1)). Addresses 9-11 drive `blk_tail` (address 9 at bits 31:0, 10 at 63:32, 11 at 95:64). Address 13 (0xD) drives `clk_set`.
- R2: Parity is odd: a frame is accepted only if the number of ones in the frame, parity bit included, is odd. Any other frame changes nothing.
- R3: A read request is 6 bits: address in bits 0-3, write flag 0 in bit 4, parity in bit 5. The next data-register scan returns the addressed word on TDO, LSB first, with bit 0 visible right after Capture-DR. Addresses 1-11 and 13 are readable.
- R4: `job_start` pulses high for exactly one cycle after each accepted write to address 11, and for no other write.
- R5: Reading address 14 (0xE) pops the oldest nonce from the result FIFO in arrival order. With the FIFO empty, the read returns 0xFFFFFFFF.
- R6: A frame whose address is unused is discarded without side effects. Unused addresses are 0, 12 and 15 for both directions, and 14 for writes.
- R7: A scan of any length other than 38 or 6 bits is discarded as a command.
- R8: The FIFO holds 16 nonces. A nonce arriving while it is full is dropped and sets `nonce_ovf`, which stays set until reset.
- R9: After reset all registers read zero, `tdo` is 0, the FIFO is empty and `nonce_ovf` is 0.
- R10: A scan that follows no valid read request shifts out zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (TCK domain) |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe, one bit per cycle |
| upd_dr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| nonce_vld | input | 1 | Nonce push from the hashing core |
| nonce | input | 32 | Nonce value |
| midstate | output | 256 | Eight midstate words |
| blk_tail | output | 96 | Three block-tail words |
| clk_set | output | 32 | Clock-setting word (twice the multiplier) |
| job_start | output | 1 | One-cycle new-job pulse |
| nonce_ovf | output | 1 | Sticky FIFO-overflow flag |

## Verification
Write frames carry a distinct value to every address, and each word is then checked both on the output ports and by serial read-back. This shows that the address decode and the LSB-first bit order are right. The same frames are also sent with the parity flipped, with an unused address, and with 37 or 32 bits instead of 38, and in each case no output may change. These cases separate the length check, the parity check and the address check. The nonce FIFO is tried three ways: with a few entries, which checks order and the all-ones empty word; filled past its depth, which checks that the newest nonce is dropped and the flag stays set; and drained to empty.

// File: rtl/jtag_reg_bridge.sv
module jtag_reg_bridge #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_dr,
  input  logic         shift_dr,
  input  logic         upd_dr,
  input  logic         tdi,
  output logic         tdo,
  input  logic         nonce_vld,
  input  logic [31:0]  nonce,
  output logic [255:0] midstate,
  output logic [95:0]  blk_tail,
  output logic [31:0]  clk_set,
  output logic         job_start,
  output logic         nonce_ovf
);
  localparam int WLEN = 38;
  localparam int RLEN = 6;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam logic [3:0] A_LAST = 4'd11;
  localparam logic [3:0] A_CLK  = 4'd13;
  localparam logic [3:0] A_RES  = 4'd14;

  logic [WLEN-1:0] sr;
  logic [5:0]      nbits;
  logic [31:0]     word_q [1:11];
  logic [31:0]     clk_q, out_q, rd_val;
  logic            rd_pend, job_q, ovf_q;
  logic [3:0]      rd_addr;
  logic [31:0]     fifo [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [CW-1:0]   cnt;

  wire [3:0] fa      = sr[35:32];
  wire       fw      = sr[36];
  wire       fa_word = (fa >= 4'd1) && (fa <= A_LAST);
  wire       wr_ok   = upd_dr && nbits == 6'(WLEN) && (^sr) && fw && (fa_word || fa == A_CLK);
  wire       rd_ok   = upd_dr && nbits == 6'(RLEN) && (^sr[37:32]) && !fw &&
                       (fa_word || fa == A_CLK || fa == A_RES);
  wire       empty   = cnt == '0;
  wire       push    = nonce_vld && cnt != CW'(DEPTH);
  wire       pop     = cap_dr && rd_pend && rd_addr == A_RES && !empty;

  always_comb begin
    if (rd_addr == A_CLK)                        rd_val = clk_q;
    else if (rd_addr == A_RES)                   rd_val = empty ? '1 : fifo[rp];
    else if (rd_addr >= 4'd1 && rd_addr <= A_LAST) rd_val = word_q[rd_addr];
    else                                         rd_val = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr      <= '0;
      nbits   <= '0;
      out_q   <= '0;
      clk_q   <= '0;
      rd_pend <= 1'b0;
      rd_addr <= '0;
      job_q   <= 1'b0;
      for (int i = 1; i <= 11; i++) word_q[i] <= '0;
    end else begin
      job_q <= wr_ok && fa == A_LAST;
      if (cap_dr) begin
        nbits   <= '0;
        out_q   <= rd_pend ? rd_val : '0;
        rd_pend <= 1'b0;
      end else if (shift_dr) begin
        sr    <= {tdi, sr[WLEN-1:1]};
        out_q <= {1'b0, out_q[31:1]};
        if (nbits != '1) nbits <= nbits + 6'd1;
      end
      if (wr_ok) begin
        if (fa == A_CLK) clk_q <= sr[31:0];
        else             word_q[fa] <= sr[31:0];
      end
      if (rd_ok) begin
        rd_pend <= 1'b1;
        rd_addr <= fa;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) fifo[wp] <= nonce;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      cnt <= cnt + CW'(push) - CW'(pop);
      if (nonce_vld && !push) ovf_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < 8; g++) begin : g_mid
    assign midstate[32*g +: 32] = word_q[g+1];
  end
  for (genvar g = 0; g < 3; g++) begin : g_tail
    assign blk_tail[32*g +: 32] = word_q[g+9];
  end

  assign tdo       = out_q[0];
  assign clk_set   = clk_q;
  assign job_start = job_q;
  assign nonce_ovf = ovf_q;
endmodule

// File: rtl/jtag_reg_bridge_chk.sv
module jtag_reg_bridge_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          upd_dr,
  input logic [37:0]   frame,
  input logic [5:0]    nbits,
  input logic [31:0]   clk_set,
  input logic          job_start,
  input logic          nonce_ovf,
  input logic          nonce_vld,
  input logic [CW-1:0] cnt
);
  a_r4_job_single: assert property (@(posedge clk) disable iff (!rst_n)
    job_start |=> !job_start);

  a_r2_badpar_keeps_clk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_dr && nbits == 6'd38 && !(^frame)) |=> $stable(clk_set));

  a_r7_len_keeps_clk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_dr && nbits != 6'd38) |=> $stable(clk_set));

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    nonce_ovf |=> nonce_ovf);

  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  a_r8_ovf_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!nonce_ovf && (cnt != CW'(DEPTH) || !nonce_vld)) |=> !nonce_ovf);
endmodule

bind jtag_reg_bridge jtag_reg_bridge_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_dr(upd_dr), .frame(sr), .nbits(nbits),
  .clk_set(clk_set), .job_start(job_start), .nonce_ovf(nonce_ovf),
  .nonce_vld(nonce_vld), .cnt(cnt)
);

// File: tb/test_jtag_reg_bridge.sv
module test_jtag_reg_bridge;
  logic clk = 0, rst_n = 0, cap_dr = 0, shift_dr = 0, upd_dr = 0, tdi = 0;
  logic nonce_vld = 0;
  logic [31:0] nonce = '0;
  logic tdo, job_start, nonce_ovf;
  logic [255:0] midstate;
  logic [95:0] blk_tail;
  logic [31:0] clk_set;
  int checks = 0, fails = 0, jobs = 0;

  jtag_reg_bridge i_jtag_reg_bridge (
    .clk(clk), .rst_n(rst_n), .cap_dr(cap_dr), .shift_dr(shift_dr), .upd_dr(upd_dr),
    .tdi(tdi), .tdo(tdo), .nonce_vld(nonce_vld), .nonce(nonce), .midstate(midstate),
    .blk_tail(blk_tail), .clk_set(clk_set), .job_start(job_start), .nonce_ovf(nonce_ovf));

  always #10 clk = ~clk;
  always @(posedge clk) if (rst_n && job_start) jobs++;

  task automatic check(string req, logic [255:0] got, logic [255:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic scan(int n, logic [37:0] vec, output logic [31:0] got);
    got = '0;
    @(negedge clk) cap_dr = 1;
    @(negedge clk) cap_dr = 0;
    for (int i = 0; i < n; i++) begin
      if (i < 32) got[i] = tdo;
      tdi = vec[i]; shift_dr = 1;
      @(negedge clk);
    end
    shift_dr = 0; upd_dr = 1;
    @(negedge clk) upd_dr = 0;
  endtask

  function automatic logic [37:0] wvec(logic [3:0] a, logic [31:0] d, bit bad);
    logic p = ~^{1'b1, a, d};
    return {p ^ bad, 1'b1, a, d};
  endfunction

  task automatic wr(logic [3:0] a, logic [31:0] d, bit bad = 0);
    logic [31:0] g;
    scan(38, wvec(a, d, bad), g);
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v, input bit bad = 0);
    logic [31:0] g;
    logic p = ~^{1'b0, a};
    scan(6, {32'd0, p ^ bad, 1'b0, a}, g);
    scan(32, '0, v);
  endtask

  task automatic push(logic [31:0] v);
    @(negedge clk) nonce_vld = 1; nonce = v;
    @(negedge clk) nonce_vld = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R9 tdo", tdo, 0);
    check("R9 midstate", midstate, 0);
    check("R9 clk_set", clk_set, 0);
    check("R9 ovf", nonce_ovf, 0);
    rd(4'd5, v);
    check("R9 word5 zero", v, 0);
    rd(4'd14, v);
    check("R5 empty read", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_write_read();
    logic [31:0] v;
    logic [255:0] em;
    logic [95:0] et;
    for (int a = 1; a <= 11; a++) wr(4'(a), 32'hA5000000 + 32'(a * 32'h01010101));
    for (int a = 1; a <= 8; a++) em[32*(a-1) +: 32] = 32'hA5000000 + 32'(a * 32'h01010101);
    for (int a = 9; a <= 11; a++) et[32*(a-9) +: 32] = 32'hA5000000 + 32'(a * 32'h01010101);
    check("R1 midstate", midstate, em);
    check("R1 blk_tail", blk_tail, et);
    wr(4'd13, 32'd380);
    check("R1 clk_set", clk_set, 380);
    rd(4'd3, v);
    check("R3 read word3", v, 32'hA5000000 + 3 * 32'h01010101);
    rd(4'd10, v);
    check("R3 read word10", v, 32'hA5000000 + 10 * 32'h01010101);
    rd(4'd13, v);
    check("R3 read clk", v, 380);
  endtask

  task automatic t_job();
    int j0 = jobs;
    wr(4'd9, 32'h1234);
    check("R4 no pulse on 9", jobs, j0);
    wr(4'd11, 32'hCAFEF00D);
    @(negedge clk);
    check("R4 pulse on 11", jobs, j0 + 1);
    check("R4 word11", blk_tail[95:64], 32'hCAFEF00D);
  endtask

  task automatic t_parity();
    logic [31:0] v;
    wr(4'd13, 32'h55, 1);
    check("R2 bad write", clk_set, 380);
    rd(4'd3, v, 1);
    check("R2 bad read gives zero (R10)", v, 0);
  endtask

  task automatic t_unused();
    logic [255:0] m = midstate;
    logic [95:0] t = blk_tail;
    logic [31:0] v;
    wr(4'd0, 32'hDEAD0000);
    wr(4'd12, 32'hDEAD000C);
    wr(4'd15, 32'hDEAD000F);
    wr(4'd14, 32'hDEAD000E);
    check("R6 midstate kept", midstate, m);
    check("R6 tail kept", blk_tail, t);
    check("R6 clk kept", clk_set, 380);
    rd(4'd14, v);
    check("R6 write to 14 not queued", v, 32'hFFFF_FFFF);
    rd(4'd12, v);
    check("R6 read unused zero", v, 0);
  endtask

  task automatic t_length();
    logic [31:0] g;
    scan(37, wvec(4'd13, 32'h77, 0), g);
    check("R7 37-bit ignored", clk_set, 380);
    scan(39, {1'b0, wvec(4'd13, 32'h77, 0)}, g);
    check("R7 39-bit ignored", clk_set, 380);
    scan(32, 38'h77, g);
    check("R7 32-bit ignored", clk_set, 380);
    check("R10 idle scan zeros", g, 0);
  endtask

  task automatic t_fifo();
    logic [31:0] v;
    push(32'h111); push(32'h222); push(32'h333);
    rd(4'd14, v); check("R5 first", v, 32'h111);
    rd(4'd14, v); check("R5 second", v, 32'h222);
    rd(4'd14, v); check("R5 third", v, 32'h333);
    rd(4'd14, v); check("R5 drained", v, 32'hFFFF_FFFF);
    check("R8 no ovf", nonce_ovf, 0);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    for (int i = 0; i < 18; i++) push(32'h9000 + 32'(i));
    check("R8 ovf set", nonce_ovf, 1);
    for (int i = 0; i < 16; i++) begin
      rd(4'd14, v);
      check("R8 order kept", v, 32'h9000 + 32'(i));
    end
    rd(4'd14, v);
    check("R8 newest dropped", v, 32'hFFFF_FFFF);
    check("R8 ovf sticky", nonce_ovf, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_job();
    t_parity();
    t_unused();
    t_length();
    t_fifo();
    t_overflow();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule